// File: doc/BRIEF.md
# Rotating-Priority Interrupt Arbiter

This block decides whether an interrupt should be raised to a processor, given eight request lines. It keeps three eight-bit registers of its own: pending requests, lines in service, and the last sampled level of every input. Each line is captured either on its level or on a rising edge, as selected per line by a trigger-mode vector. A three-bit rotation offset decides which line is ranked first. Lines after it follow in circular order.

Each cycle the block takes the unmasked pending requests and finds the best-ranked one. It raises the interrupt only when that request ranks strictly above every line still in service. Two options change which in-service lines take part in that comparison: a special-mask option and a nested option that applies to the cascade line. The winner's number is presented with the interrupt flag. An acknowledge pulse moves the winner into service, or, in automatic end-of-service mode, may instead rotate the priority so the winner becomes lowest. The mask, the mode bits, the in-service clear vector and offset writes arrive as ports from a separate command decoder.

Top module: `irq_rank_arbiter`

## Requirements
- R1: A line's rank is (line - offset) mod 8, and rank 0 is the best. A cycle with `rot_wr` high loads `rot_val` into the offset (`rot_offset`). This load takes precedence over any rotation caused by an acknowledge in the same cycle.
- R2: The candidate set is the pending vector with masked lines removed (`mask_in` bit 1 = masked). When the candidate set is empty, `irq_out` is low. When `irq_out` is high, `win_line` names the best-ranked candidate.
- R3: `irq_out` is high only when the best candidate rank is strictly better than the best rank among in-service lines. A candidate of equal rank does not fire.
- R4: With `special_mask` high, in-service lines that are masked are left out of the in-service rank.
- R5: With `nested_mode` and `is_master` both high, in-service line 2 is left out of the in-service rank. With `is_master` low, line 2 counts as normal.
- R6: A level-triggered line (`trig_mode` bit 1) sets its pending bit while its input is high and clears it while the input is low. An edge-triggered line (bit 0) sets its pending bit only on a low-to-high input transition, and the bit stays set after the input falls.
- R7: An acknowledge is taken when `ack` is high while `irq_out` is high. Without automatic end-of-service, the `win_line` in-service bit is set. With automatic end-of-service and rotate-on-auto enabled, the offset becomes `win_line`+1 mod 8 and the in-service bits are unchanged. A bit set in `isr_clr` clears the matching in-service bit in that cycle.
- R8: A taken acknowledge clears the winner's pending bit only when that line is edge-triggered. Level-triggered pending bits are unaffected.
- R9: `irq_out` and `win_line` are registered. They show the register state and mask after each clock edge, so any input change appears after one clock.
- R10: Synchronous active-high `rst` clears the pending, in-service and previous-level registers, the offset and `irq_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_in | input | 8 | Raw request lines |
| trig_mode | input | 8 | Per-line trigger mode, 1 = level, 0 = edge |
| mask_in | input | 8 | Per-line mask, 1 = masked |
| special_mask | input | 1 | Leave masked in-service lines out of the comparison |
| nested_mode | input | 1 | Leave the cascade line out of the comparison (master only) |
| is_master | input | 1 | This controller is the master of a cascade |
| auto_eoi | input | 1 | Acknowledge does not set in-service bits |
| rotate_on_aeoi | input | 1 | Rotate priority on acknowledge in automatic mode |
| rot_wr | input | 1 | Load the rotation offset |
| rot_val | input | 3 | Offset value to load |
| isr_clr | input | 8 | In-service bits to clear this cycle |
| ack | input | 1 | Acknowledge the presented winner |
| irq_out | output | 1 | Interrupt request / winner valid |
| win_line | output | 3 | Winning line number |
| req_pend | output | 8 | Pending request register |
| in_serv | output | 8 | In-service register |
| rot_offset | output | 3 | Current rotation offset |

## Verification
The embedded properties check a set of invariants on every cycle:
- a presented winner is pending, was unmasked, and (unless it is the cascade line) is not already in service;
- level lines follow their input, and edge lines only rise after a low sample;
- an acknowledge sets the in-service bit or rotates the offset;
- clear requests take effect.

Other behaviours need the bench's scenarios to show them:
- the actual winner choice under different rotation offsets;
- the strict-rank refusal for an equal-rank candidate;
- the special-mask and nested exemptions;
- a held edge input that is not taken again after being acknowledged.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

    localparam int unsigned N_LINES      = 8;
    localparam int unsigned LINE_W       = $clog2(N_LINES);
    localparam int unsigned RANK_W       = LINE_W + 1;
    localparam int unsigned CASCADE_LINE = 2;

    typedef logic [N_LINES-1:0] lvec_t;
    typedef logic [LINE_W-1:0]  line_t;
    typedef logic [RANK_W-1:0]  rank_t;

    localparam rank_t RANK_NONE = rank_t'(N_LINES);

    typedef enum logic {
        TRIG_EDGE  = 1'b0,
        TRIG_LEVEL = 1'b1
    } trig_e;

    typedef struct packed {
        logic  fire;
        line_t line;
    } grant_t;

    typedef struct packed {
        logic smm;
        logic nested;
        logic master;
    } pmode_t;

    // Reorder a line vector so that bit k holds the line of rank k.
    function automatic lvec_t to_rank_order(lvec_t v, line_t ofs);
        lvec_t r;
        for (int k = 0; k < N_LINES; k++) begin
            r[k] = v[(k + int'(ofs)) % N_LINES];
        end
        return r;
    endfunction

    // Lowest set index of a rank-ordered vector, RANK_NONE if empty.
    function automatic rank_t first_rank(lvec_t v);
        rank_t r;
        r = RANK_NONE;
        for (int k = N_LINES - 1; k >= 0; k--) begin
            if (v[k]) r = rank_t'(k);
        end
        return r;
    endfunction

    function automatic line_t rank_line(rank_t r, line_t ofs);
        return line_t'((int'(r) + int'(ofs)) % N_LINES);
    endfunction

endpackage

// File: rtl/irq_req_latch.sv
module irq_req_latch
    import irq_arb_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  lvec_t req_in,
    input  lvec_t trig,
    input  lvec_t ack_clr,
    output lvec_t irr_d,
    output lvec_t irr_q
);

    lvec_t prev_q;

    for (genvar i = 0; i < N_LINES; i++) begin : g_line
        always_comb begin
            if (trig_e'(trig[i]) == TRIG_LEVEL) begin
                irr_d[i] = req_in[i];
            end else begin
                irr_d[i] = (irr_q[i] | (req_in[i] & ~prev_q[i])) & ~ack_clr[i];
            end
        end

        // R6: a level line mirrors its input one clock later
        a_r6_level_track: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && $past(trig[i])) |-> (irr_q[i] == $past(req_in[i])));

        // R6: an edge line only becomes pending after a rising input
        a_r6_edge_rise: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && !$past(trig[i]) && !$past(irr_q[i]) && irr_q[i])
            |-> ($past(req_in[i]) && !$past(prev_q[i])));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irr_q  <= '0;
            prev_q <= '0;
        end else begin
            irr_q  <= irr_d;
            prev_q <= req_in;
        end
    end

endmodule

// File: rtl/irq_prio_resolver.sv
module irq_prio_resolver
    import irq_arb_pkg::*;
(
    input  lvec_t  irr,
    input  lvec_t  mask,
    input  lvec_t  isr,
    input  line_t  ofs,
    input  pmode_t mode,
    output grant_t grant
);

    lvec_t cand;
    lvec_t svc;
    rank_t cand_rank;
    rank_t svc_rank;

    always_comb begin
        cand = irr & ~mask;
        svc  = isr;
        if (mode.smm) begin
            svc = svc & ~mask;
        end
        if (mode.nested && mode.master) begin
            svc[CASCADE_LINE] = 1'b0;
        end
        cand_rank = first_rank(to_rank_order(cand, ofs));
        svc_rank  = first_rank(to_rank_order(svc, ofs));

        grant.fire = (cand_rank != RANK_NONE) && (cand_rank < svc_rank);
        grant.line = grant.fire ? rank_line(cand_rank, ofs) : '0;
    end

endmodule

// File: rtl/irq_service_ctrl.sv
module irq_service_ctrl
    import irq_arb_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  take,
    input  line_t take_line,
    input  logic  auto_eoi,
    input  logic  rot_aeoi,
    input  lvec_t isr_clr,
    input  logic  rot_wr,
    input  line_t rot_val,
    output lvec_t isr_d,
    output lvec_t isr_q,
    output line_t ofs_d,
    output line_t ofs_q
);

    always_comb begin
        isr_d = isr_q & ~isr_clr;
        ofs_d = ofs_q;
        if (take) begin
            if (!auto_eoi) begin
                isr_d[take_line] = 1'b1;
            end else if (rot_aeoi) begin
                ofs_d = line_t'(take_line + 1'b1);
            end
        end
        if (rot_wr) begin
            ofs_d = rot_val;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            isr_q <= '0;
            ofs_q <= '0;
        end else begin
            isr_q <= isr_d;
            ofs_q <= ofs_d;
        end
    end

    // R7: acknowledge outside automatic mode leaves the winner in service
    a_r7_ack_sets_isr: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(take) && !$past(auto_eoi)) |-> isr_q[$past(take_line)]);

    // R7: automatic rotate makes the acknowledged line lowest ranked
    a_r7_aeoi_rotate: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(take && auto_eoi && rot_aeoi && !rot_wr))
        |-> (ofs_q == line_t'($past(take_line) + 1'b1)));

    // R7: requested clears always land when nothing is acknowledged
    a_r7_clear_lands: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(take)) |-> ((isr_q & $past(isr_clr)) == '0));

    // R1: an offset write is honoured
    a_r1_offset_load: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(rot_wr)) |-> (ofs_q == $past(rot_val)));

endmodule

// File: rtl/irq_rank_arbiter.sv
module irq_rank_arbiter
    import irq_arb_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] req_in,
    input  logic [7:0] trig_mode,
    input  logic [7:0] mask_in,
    input  logic       special_mask,
    input  logic       nested_mode,
    input  logic       is_master,
    input  logic       auto_eoi,
    input  logic       rotate_on_aeoi,
    input  logic       rot_wr,
    input  logic [2:0] rot_val,
    input  logic [7:0] isr_clr,
    input  logic       ack,
    output logic       irq_out,
    output logic [2:0] win_line,
    output logic [7:0] req_pend,
    output logic [7:0] in_serv,
    output logic [2:0] rot_offset
);

    grant_t grant_d;
    grant_t grant_q;
    lvec_t  irr_d;
    lvec_t  irr_q;
    lvec_t  isr_d;
    lvec_t  isr_q;
    line_t  ofs_d;
    line_t  ofs_q;
    lvec_t  ack_clr;
    logic   take;
    pmode_t mode;
    lvec_t  mask_seen;

    assign take = ack && grant_q.fire;
    assign mode = '{smm: special_mask, nested: nested_mode, master: is_master};

    always_comb begin
        ack_clr = '0;
        if (take) begin
            ack_clr[grant_q.line] = ~trig_mode[grant_q.line];
        end
    end

    irq_req_latch u_latch (
        .clk     (clk),
        .rst     (rst),
        .req_in  (req_in),
        .trig    (trig_mode),
        .ack_clr (ack_clr),
        .irr_d   (irr_d),
        .irr_q   (irr_q)
    );

    irq_service_ctrl u_service (
        .clk       (clk),
        .rst       (rst),
        .take      (take),
        .take_line (grant_q.line),
        .auto_eoi  (auto_eoi),
        .rot_aeoi  (rotate_on_aeoi),
        .isr_clr   (isr_clr),
        .rot_wr    (rot_wr),
        .rot_val   (rot_val),
        .isr_d     (isr_d),
        .isr_q     (isr_q),
        .ofs_d     (ofs_d),
        .ofs_q     (ofs_q)
    );

    irq_prio_resolver u_resolver (
        .irr   (irr_d),
        .mask  (mask_in),
        .isr   (isr_d),
        .ofs   (ofs_d),
        .mode  (mode),
        .grant (grant_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            grant_q   <= '0;
            mask_seen <= '0;
        end else begin
            grant_q   <= grant_d;
            mask_seen <= mask_in;
        end
    end

    assign irq_out    = grant_q.fire;
    assign win_line   = grant_q.line;
    assign req_pend   = irr_q;
    assign in_serv    = isr_q;
    assign rot_offset = ofs_q;

    // R2: a presented winner is pending
    a_r2_win_pending: assert property (@(posedge clk) disable iff (rst)
        irq_out |-> req_pend[win_line]);

    // R2: a presented winner was unmasked at the edge that chose it
    a_r2_win_unmasked: assert property (@(posedge clk) disable iff (rst)
        irq_out |-> !mask_seen[win_line]);

    // R3: a winner outside the cascade exemption is never already in service
    a_r3_not_in_service: assert property (@(posedge clk) disable iff (rst)
        (irq_out && (win_line != line_t'(CASCADE_LINE))) |-> !in_serv[win_line]);

endmodule

// File: tb/test_irq_rank_arbiter.sv
`timescale 1ns/1ps
module test_irq_rank_arbiter;

    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] req_in, trig_mode, mask_in, isr_clr;
    logic       special_mask, nested_mode, is_master, auto_eoi, rotate_on_aeoi;
    logic       rot_wr, ack;
    logic [2:0] rot_val;
    logic       irq_out;
    logic [2:0] win_line, rot_offset;
    logic [7:0] req_pend, in_serv;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    irq_rank_arbiter i_irq_rank_arbiter (
        .clk(clk), .rst(rst), .req_in(req_in), .trig_mode(trig_mode),
        .mask_in(mask_in), .special_mask(special_mask), .nested_mode(nested_mode),
        .is_master(is_master), .auto_eoi(auto_eoi), .rotate_on_aeoi(rotate_on_aeoi),
        .rot_wr(rot_wr), .rot_val(rot_val), .isr_clr(isr_clr), .ack(ack),
        .irq_out(irq_out), .win_line(win_line), .req_pend(req_pend),
        .in_serv(in_serv), .rot_offset(rot_offset)
    );

    // {offset, mask, level requests, expected irq, expected line}
    localparam logic [22:0] VEC [0:9] = '{
        {3'd0, 8'h00, 8'h00, 1'b0, 3'd0},
        {3'd0, 8'h00, 8'h81, 1'b1, 3'd0},
        {3'd0, 8'h00, 8'h80, 1'b1, 3'd7},
        {3'd3, 8'h00, 8'h05, 1'b1, 3'd0},
        {3'd3, 8'h00, 8'h18, 1'b1, 3'd3},
        {3'd5, 8'h00, 8'h11, 1'b1, 3'd0},
        {3'd7, 8'h00, 8'h41, 1'b1, 3'd0},
        {3'd0, 8'h01, 8'h03, 1'b1, 3'd1},
        {3'd0, 8'hFF, 8'hFF, 1'b0, 3'd0},
        {3'd4, 8'h10, 8'h30, 1'b1, 3'd5}
    };

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        req_in = '0; trig_mode = 8'hFF; mask_in = '0; isr_clr = '0;
        special_mask = 0; nested_mode = 0; is_master = 0;
        auto_eoi = 0; rotate_on_aeoi = 0; rot_wr = 0; rot_val = '0; ack = 0;
        repeat (3) step();
        rst = 1'b0;
        step();
    endtask

    task automatic pulse_ack();
        ack = 1'b1;
        step();
        ack = 1'b0;
    endtask

    initial begin
        #1;
        do_reset();
        chk("R10 reset irq", irq_out, 0);
        chk("R10 reset pending", req_pend, 0);
        chk("R10 reset in-service", in_serv, 0);
        chk("R10 reset offset", rot_offset, 0);

        // R1 R2 R9: rotation and masking with level lines, nothing in service
        for (int v = 0; v < 10; v++) begin
            rot_wr  = 1'b1;
            rot_val = VEC[v][22:20];
            mask_in = VEC[v][19:12];
            req_in  = VEC[v][11:4];
            step();
            rot_wr = 1'b0;
            chk("R1 offset", rot_offset, VEC[v][22:20]);
            chk("R2 irq", irq_out, VEC[v][3]);
            if (VEC[v][3]) chk("R1 winner", win_line, VEC[v][2:0]);
        end

        // R3 R7 R8: in-service comparison, level lines
        rot_wr = 1; rot_val = 0; mask_in = 0; req_in = 8'h10;
        step(); rot_wr = 0;
        chk("R2 line4 irq", irq_out, 1);
        chk("R2 line4 winner", win_line, 4);
        pulse_ack();
        chk("R7 isr set", in_serv, 8'h10);
        chk("R8 level kept", req_pend, 8'h10);
        chk("R3 equal rank blocked", irq_out, 0);
        req_in = 8'h50; step();
        chk("R3 worse rank blocked", irq_out, 0);
        req_in = 8'h54; step();
        chk("R3 better rank fires", irq_out, 1);
        chk("R3 better rank line", win_line, 2);
        pulse_ack();
        chk("R7 nested isr", in_serv, 8'h14);
        chk("R3 blocked after nest", irq_out, 0);

        // R4: special mask
        mask_in = 8'h14; step();
        chk("R4 no special mask", irq_out, 0);
        special_mask = 1; step();
        chk("R4 special mask irq", irq_out, 1);
        chk("R4 special mask line", win_line, 6);

        // R5: nested exemption for the cascade line
        special_mask = 0; mask_in = 0; req_in = 8'h04; isr_clr = 8'hFF;
        step(); isr_clr = 0;
        chk("R7 isr cleared", in_serv, 0);
        chk("R5 line2 irq", irq_out, 1);
        is_master = 1;
        pulse_ack();
        chk("R5 line2 in service", in_serv, 8'h04);
        chk("R5 blocked without nested", irq_out, 0);
        nested_mode = 1; step();
        chk("R5 nested master fires", irq_out, 1);
        chk("R5 nested master line", win_line, 2);
        is_master = 0; step();
        chk("R5 slave not exempt", irq_out, 0);

        // R6 R8: edge lines
        do_reset();
        trig_mode = 8'h00; step();
        req_in = 8'h08; step();
        chk("R6 edge latched", req_pend, 8'h08);
        chk("R6 edge irq line", win_line, 3);
        req_in = 8'h00; step();
        chk("R6 edge held after fall", req_pend, 8'h08);
        pulse_ack();
        chk("R8 edge cleared", req_pend, 8'h00);
        chk("R7 edge in service", in_serv, 8'h08);
        chk("R3 edge no irq", irq_out, 0);
        req_in = 8'h08; step();
        chk("R6 new edge", req_pend, 8'h08);
        isr_clr = 8'hFF; step(); isr_clr = 0;
        chk("R9 irq after clear", irq_out, 1);
        pulse_ack();
        chk("R8 edge cleared again", req_pend, 8'h00);
        isr_clr = 8'hFF; step(); isr_clr = 0;
        step();
        chk("R6 held high no retrigger", req_pend, 8'h00);
        chk("R6 held high no irq", irq_out, 0);

        // R7: automatic end-of-service
        do_reset();
        req_in = 8'h20; step();
        chk("R2 line5 irq", irq_out, 1);
        auto_eoi = 1; rotate_on_aeoi = 1;
        pulse_ack();
        chk("R7 auto rotate offset", rot_offset, 6);
        chk("R7 auto no isr", in_serv, 0);
        chk("R8 auto level kept", req_pend, 8'h20);
        chk("R7 auto still fires", irq_out, 1);
        rotate_on_aeoi = 0; rot_val = 0;
        pulse_ack();
        chk("R7 auto no rotate", rot_offset, 6);
        rot_wr = 1; rot_val = 3'd1; rotate_on_aeoi = 1; ack = 1;
        step(); ack = 0; rot_wr = 0;
        chk("R1 write beats rotate", rot_offset, 1);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

endmodule